// File: doc/BRIEF.md
# Temperature Trip Flag Tracker

This block takes a stream of signed temperature samples and compares each one against three programmable limits: an upper alarm limit, a lower alarm limit and a critical limit. The result is three sticky trip flags. Each flag sets at one threshold and releases at a different one. The gap between the two is a selectable hysteresis, so a reading that sits near a limit does not make its flag toggle on every sample.

The block also builds the readback temperature word. The latest sample sits in the middle field of that word, and the three flags sit in its top bits. Samples arrive on a valid/ready stream and are always accepted. The thresholds and the hysteresis select are plain control inputs, sampled only on the cycle a sample is accepted.

Temperatures are 11-bit two's complement values with a weight of 0.25 °C per LSB. For example, 25.75 °C is 103 and −40 °C is 0x760. The sample is sent directly as 11 bits. Each 16-bit threshold word carries its value in bits 12:2, in the same format as the readback word.

Top module: `thermal_trip_tracker`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted sample, all three flags are 0 and `temp_word` is 0x0000.
- R2: `smp_ready` is always 1. A sample is accepted on each rising clock edge with `smp_valid` high. From the next cycle, `temp_word[12:2]` holds the sample and `temp_word[1:0]` reads 0.
- R3: Only bits 12:2 of each threshold word are used, with bit 12 as the sign. Bits 15:13 and 1:0 of a threshold word have no effect on any flag.
- R4: `hyst_sel` selects the hysteresis H used for a sample: 00 gives 0 LSB, 01 gives 6 LSB (1.5 °C), 10 gives 12 LSB (3 °C) and 11 gives 24 LSB (6 °C).
- R5: The above flag sets on a sample T with T > upper.
- R6: The above flag clears on a sample with T <= upper − H. For upper − H < T <= upper it keeps its value.
- R7: The below flag sets on a sample with T < lower − H. It clears on a sample with T >= lower. Between these two points it keeps its value.
- R8: The critical flag sets on a sample with T >= critical. It clears on a sample with T < critical − H. Otherwise it keeps its value.
- R9: `temp_word[15]` is the critical flag, `temp_word[14]` is the above flag and `temp_word[13]` is the below flag. Each bit always equals the corresponding flag output.
- R10: In a cycle with `smp_valid` low, no output changes, even when the thresholds, the hysteresis select or the sample bus change.
- R11: All comparisons are signed, so negative samples, such as −40 °C against a lower limit of 10 °C, compare correctly and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, always 1 |
| smp_temp | input | 11 | Two's complement sample, 0.25 °C/LSB |
| thr_upper | input | 16 | Upper alarm limit word, value in bits 12:2 |
| thr_lower | input | 16 | Lower alarm limit word, value in bits 12:2 |
| thr_crit | input | 16 | Critical limit word, value in bits 12:2 |
| hyst_sel | input | 2 | Hysteresis select |
| flag_crit | output | 1 | Critical trip flag |
| flag_above | output | 1 | Above-window flag |
| flag_below | output | 1 | Below-window flag |
| temp_word | output | 16 | Readback word: flags in 15:13, sample in 12:2 |

## Verification
Several things can change on the same accepted sample: one flag can set while another clears, two flags can set together, and the temperature field updates along with the flags. The stimulus provokes these cases directly. A single jump from above the upper limit to below the lower limit must clear the above flag and set the below flag in the same cycle. A rise past the critical limit must set both the critical and above flags. A drop just under critical − H must clear the critical flag while the above flag holds. In every case, the bench predicts the whole 16-bit word for the cycle after acceptance and compares it against both the word and the separate flag outputs.

// File: rtl/thermal_trip_pkg.sv
package thermal_trip_pkg;
  localparam int NUM_FLAGS = 3;

  // flag index doubles as bit offset above the temperature field
  typedef enum int {
    FLG_BELOW = 0,
    FLG_ABOVE = 1,
    FLG_CRIT  = 2
  } flag_idx_e;

  // per flag: compares against the high side of the window
  localparam logic [NUM_FLAGS-1:0] SIDE_HIGH = 3'b110;
  // per flag: set point is inclusive (>=)
  localparam logic [NUM_FLAGS-1:0] SET_INCL  = 3'b100;

  // hysteresis in LSBs: none, unit, 2*unit, 4*unit
  function automatic int hyst_scale(input logic [1:0] code, input int unit);
    return (code == 2'd0) ? 0 : (unit << (int'(code) - 1));
  endfunction
endpackage

// File: rtl/trip_flag_cell.sv
module trip_flag_cell #(
  parameter int W         = 13,
  parameter bit HIGH_SIDE = 1'b1,
  parameter bit INCL      = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd,
  input  logic signed [W-1:0] smp,
  input  logic signed [W-1:0] thr,
  input  logic signed [W-1:0] hys,
  output logic                flag
);
  logic signed [W-1:0] thr_shift;
  logic                set_c, clr_c;

  function automatic logic beyond(input logic signed [W-1:0] a,
                                  input logic signed [W-1:0] b);
    if (HIGH_SIDE) return INCL ? (a >= b) : (a > b);
    else           return a < b;
  endfunction

  always_comb begin
    thr_shift = thr - hys;
    if (HIGH_SIDE) begin
      set_c = beyond(smp, thr);
      clr_c = !beyond(smp, thr_shift);
    end else begin
      set_c = beyond(smp, thr_shift);
      clr_c = !beyond(smp, thr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                flag <= 1'b0;
    else if (upd && set_c)     flag <= 1'b1;
    else if (upd && clr_c)     flag <= 1'b0;
  end
endmodule

// File: rtl/temp_word_fmt.sv
module temp_word_fmt #(
  parameter int SMP_W   = 11,
  parameter int LSB_POS = 2,
  parameter int NF      = 3,
  localparam int WORD_W = NF + SMP_W + LSB_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [SMP_W-1:0]  smp,
  input  logic [NF-1:0]     flags,
  output logic [WORD_W-1:0] word
);
  logic [SMP_W-1:0] smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   smp_q <= '0;
    else if (upd) smp_q <= smp;
  end

  assign word = {flags, smp_q, {LSB_POS{1'b0}}};
endmodule

// File: rtl/thermal_trip_tracker.sv
module thermal_trip_tracker
  import thermal_trip_pkg::*;
#(
  parameter int SMP_W     = 11,
  parameter int LSB_POS   = 2,
  parameter int HYST_UNIT = 6,
  localparam int WORD_W   = NUM_FLAGS + SMP_W + LSB_POS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_temp,
  input  logic [WORD_W-1:0] thr_upper,
  input  logic [WORD_W-1:0] thr_lower,
  input  logic [WORD_W-1:0] thr_crit,
  input  logic [1:0]        hyst_sel,
  output logic              flag_crit,
  output logic              flag_above,
  output logic              flag_below,
  output logic [WORD_W-1:0] temp_word
);
  localparam int CMP_W = SMP_W + 2;
  localparam int FLD_HI = SMP_W + LSB_POS - 1;

  logic                    accept;
  logic signed [CMP_W-1:0] smp_s, hys_s;
  logic [WORD_W-1:0]       thr_word [NUM_FLAGS];
  logic signed [CMP_W-1:0] thr_s    [NUM_FLAGS];
  logic [NUM_FLAGS-1:0]    flags;

  assign smp_ready = 1'b1;
  assign accept    = smp_valid;

  assign thr_word[FLG_BELOW] = thr_lower;
  assign thr_word[FLG_ABOVE] = thr_upper;
  assign thr_word[FLG_CRIT]  = thr_crit;

  always_comb begin
    smp_s = {{(CMP_W-SMP_W){smp_temp[SMP_W-1]}}, smp_temp};
    hys_s = CMP_W'(hyst_scale(hyst_sel, HYST_UNIT));
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      assign thr_s[gi] = {{(CMP_W-SMP_W){thr_word[gi][FLD_HI]}},
                          thr_word[gi][FLD_HI:LSB_POS]};
      trip_flag_cell #(
        .W        (CMP_W),
        .HIGH_SIDE(SIDE_HIGH[gi]),
        .INCL     (SET_INCL[gi])
      ) cell_i (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (accept),
        .smp  (smp_s),
        .thr  (thr_s[gi]),
        .hys  (hys_s),
        .flag (flags[gi])
      );
    end
  endgenerate

  // threshold bits outside the value field are ignored
  logic unused_thr_bits;
  assign unused_thr_bits = ^{thr_upper[WORD_W-1:FLD_HI+1], thr_upper[LSB_POS-1:0],
                             thr_lower[WORD_W-1:FLD_HI+1], thr_lower[LSB_POS-1:0],
                             thr_crit[WORD_W-1:FLD_HI+1],  thr_crit[LSB_POS-1:0]};

  temp_word_fmt #(
    .SMP_W  (SMP_W),
    .LSB_POS(LSB_POS),
    .NF     (NUM_FLAGS)
  ) fmt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .upd  (accept),
    .smp  (smp_temp),
    .flags(flags),
    .word (temp_word)
  );

  assign flag_crit  = flags[FLG_CRIT];
  assign flag_above = flags[FLG_ABOVE];
  assign flag_below = flags[FLG_BELOW];
endmodule

// File: rtl/thermal_trip_chk.sv
module thermal_trip_chk #(
  parameter int SMP_W   = 11,
  parameter int LSB_POS = 2,
  localparam int WORD_W = 3 + SMP_W + LSB_POS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic [SMP_W-1:0]  smp_temp,
  input logic [WORD_W-1:0] thr_upper,
  input logic [WORD_W-1:0] thr_lower,
  input logic [WORD_W-1:0] thr_crit,
  input logic              flag_crit,
  input logic              flag_above,
  input logic              flag_below,
  input logic [WORD_W-1:0] temp_word
);
  localparam int CW = SMP_W + 2;
  localparam int HI = SMP_W + LSB_POS - 1;

  logic signed [CW-1:0] t_s, u_s, l_s, c_s;
  always_comb begin
    t_s = {{2{smp_temp[SMP_W-1]}}, smp_temp};
    u_s = {{2{thr_upper[HI]}}, thr_upper[HI:LSB_POS]};
    l_s = {{2{thr_lower[HI]}}, thr_lower[HI:LSB_POS]};
    c_s = {{2{thr_crit[HI]}},  thr_crit[HI:LSB_POS]};
  end

  logic unused_chk;
  assign unused_chk = ^{thr_upper[WORD_W-1:HI+1], thr_upper[LSB_POS-1:0],
                        thr_lower[WORD_W-1:HI+1], thr_lower[LSB_POS-1:0],
                        thr_crit[WORD_W-1:HI+1],  thr_crit[LSB_POS-1:0]};

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R1: assert (temp_word == '0 && !flag_crit && !flag_above && !flag_below);
    end
  end

  assert_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    temp_word[LSB_POS-1:0] == '0);

  assert_field_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> temp_word[HI:LSB_POS] == $past(smp_temp));

  assert_above_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (t_s > u_s)) |=> flag_above);

  assert_below_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (t_s >= l_s)) |=> !flag_below);

  assert_crit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (t_s >= c_s)) |=> flag_crit);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(temp_word) && $stable(flag_crit) && $stable(flag_above) && $stable(flag_below));
endmodule

bind thermal_trip_tracker thermal_trip_chk #(
  .SMP_W  (SMP_W),
  .LSB_POS(LSB_POS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .smp_temp  (smp_temp),
  .thr_upper (thr_upper),
  .thr_lower (thr_lower),
  .thr_crit  (thr_crit),
  .flag_crit (flag_crit),
  .flag_above(flag_above),
  .flag_below(flag_below),
  .temp_word (temp_word)
);

// File: tb/thermal_trip_tracker_tb_top.sv
module thermal_trip_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [10:0] smp_temp = '0;
  logic [15:0] thr_upper, thr_lower, thr_crit;
  logic [1:0]  hyst_sel = 2'd0;
  logic        flag_crit, flag_above, flag_below;
  logic [15:0] temp_word;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  thermal_trip_tracker dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .smp_temp  (smp_temp),
    .thr_upper (thr_upper),
    .thr_lower (thr_lower),
    .thr_crit  (thr_crit),
    .hyst_sel  (hyst_sel),
    .flag_crit (flag_crit),
    .flag_above(flag_above),
    .flag_below(flag_below),
    .temp_word (temp_word)
  );

  // upper 80 C (320), lower 10 C (40), critical 90 C (360)
  // upper and lower words carry junk outside bits 12:2 (R3)
  localparam logic [15:0] UPPER_W = 16'hE503;
  localparam logic [15:0] LOWER_W = 16'h60A1;
  localparam logic [15:0] CRIT_W  = 16'h05A0;

  // {temp[10:0], hyst[1:0], expected {crit,above,below}}
  localparam int NV = 26;
  localparam logic [15:0] VEC [NV] = '{
    {11'd100, 2'd2, 3'b000},  // inside window
    {11'd321, 2'd2, 3'b010},  // R5 above sets
    {11'd320, 2'd2, 3'b010},  // R6 hold at limit
    {11'd309, 2'd2, 3'b010},  // R6 hold
    {11'd308, 2'd2, 3'b000},  // R6 clear at upper-12
    {11'd360, 2'd2, 3'b110},  // R8 crit and above set together
    {11'd349, 2'd2, 3'b110},  // R8 hold
    {11'd347, 2'd2, 3'b010},  // R8 clear, above holds
    {11'd40,  2'd2, 3'b000},  // R7 below stays clear at lower
    {11'd28,  2'd2, 3'b000},  // R7 not below lower-12
    {11'd27,  2'd2, 3'b001},  // R7 sets
    {11'd39,  2'd2, 3'b001},  // R7 hold
    {11'd40,  2'd2, 3'b000},  // R7 clear
    {11'h760, 2'd2, 3'b001},  // R11 -40 C
    {11'd40,  2'd0, 3'b000},  // R4 code 00
    {11'd39,  2'd0, 3'b001},
    {11'd40,  2'd0, 3'b000},
    {11'd321, 2'd3, 3'b010},  // R4 code 11 (24)
    {11'd297, 2'd3, 3'b010},
    {11'd296, 2'd3, 3'b000},
    {11'd400, 2'd1, 3'b110},  // R4 code 01 (6)
    {11'd354, 2'd1, 3'b110},
    {11'd353, 2'd1, 3'b010},
    {11'd314, 2'd1, 3'b000},
    {11'd321, 2'd1, 3'b010},
    {11'd0,   2'd1, 3'b001}   // above clears while below sets
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] t, input logic [1:0] h);
    @(negedge clk);
    smp_temp  = t;
    hyst_sel  = h;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    thr_upper = UPPER_W;
    thr_lower = LOWER_W;
    thr_crit  = CRIT_W;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 word in reset", temp_word, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 word after reset", temp_word, 16'h0000);
    check("R1 flags after reset", {13'd0, flag_crit, flag_above, flag_below}, 16'h0000);
    check("R2 ready high", {15'd0, smp_ready}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i][15:5], VEC[i][4:3]);
      check($sformatf("R3/R5/R6/R7/R8/R9/R11 vector %0d word", i),
            temp_word, {VEC[i][2:0], VEC[i][15:5], 2'b00});
      check($sformatf("R9 vector %0d flag pins", i),
            {13'd0, flag_crit, flag_above, flag_below}, {13'd0, VEC[i][2:0]});
    end

    // R10: idle cycles with every control moving
    @(negedge clk);
    smp_temp  = 11'd400;
    hyst_sel  = 2'd3;
    thr_lower = 16'h1C00;
    thr_crit  = 16'h0000;
    repeat (5) @(negedge clk);
    check("R10 idle hold", temp_word, {3'b001, 11'd0, 2'b00});

    // R3: junk in bits 15:13 alone must not turn a positive limit negative
    thr_upper = 16'hE004;  // field = +1
    thr_lower = 16'hE000;  // field = 0
    thr_crit  = 16'h0400;  // field = 256
    send(11'd1, 2'd0);
    check("R3 upper field +1 not exceeded", temp_word, {3'b000, 11'd1, 2'b00});
    send(11'd2, 2'd0);
    check("R3 upper field +1 exceeded", temp_word, {3'b010, 11'd2, 2'b00});

    // R2: new sample on consecutive cycles
    @(negedge clk);
    smp_valid = 1'b1; smp_temp = 11'd5;
    @(negedge clk);
    check("R2 back-to-back first", temp_word, {3'b010, 11'd5, 2'b00});
    smp_temp = 11'h7FF;  // -1: below lower 0
    @(negedge clk);
    smp_valid = 1'b0;
    check("R2 back-to-back second", temp_word, {3'b001, 11'h7FF, 2'b00});

    // R1: reset mid-run clears
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run", temp_word, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule